// File: doc/BRIEF.md
# Eight-Way Age-Ranked Replacement Tracker

This block decides which way of an 8-way set-associative cache to evict. For every set it keeps an exact recency order as a 3-bit age per way. Age 0 marks the way touched most recently and age 7 the way left alone longest. Tags, data, hit detection and the refill path live elsewhere. The cache controller reports each hit with its set and way, and asks for a victim by naming a set.

A replacement request returns the victim way in the same cycle, as a combinational output. On the following clock edge the victim becomes the youngest way and every other way in that set ages by one step. A hit makes the hit way the youngest and ages only the ways that were younger than it. The ages in every set therefore stay a permutation of 0 to 7 at all times. A hit and a replacement may arrive in the same cycle. When they name different sets, both are applied. When they name the same set, only the replacement is applied.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, the age of way w in every set equals w. The first replacement in any set therefore returns way 7, and the next ones return 6, 5, and so on.
- R2: When repl_valid is high, victim_way is the way with the largest age (7) in set repl_set. It is valid in the same cycle as the request.
- R3: A replacement sets the victim's age to 0 and raises every other age in that set by one. No age passes 7, and the ages of the set remain a permutation of 0 to 7.
- R4: A hit to way w sets w's age to 0. It raises by one only those ages in the set that were below w's previous age, and it leaves older ways unchanged.
- R5: A hit to the way whose age is already 0 leaves the set's order unchanged.
- R6: When hit_valid and repl_valid are both high and hit_set equals repl_set, only the replacement is applied and the hit has no effect.
- R7: When a hit and a replacement name different sets in the same cycle, both updates are applied.
- R8: A set that no request names keeps its ages unchanged.
- R9: When hit_valid is low, hit_set and hit_way have no effect. When repl_valid is low, no ages change because of repl_set.
- R10: Age updates take effect on the clock edge that ends the request cycle. A replacement request sees the order left by all earlier cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_valid | input | 1 | A hit update is requested this cycle |
| hit_set | input | 4 | Set index of the hit |
| hit_way | input | 3 | Way that hit |
| repl_valid | input | 1 | A victim is requested this cycle |
| repl_set | input | 4 | Set index for the replacement |
| victim_way | output | 3 | Way chosen for eviction in repl_set |

## Verification
A wrong age anywhere inside this block can only be seen through the victims it returns. A counter that is corrupted, duplicated or updated too early changes the sequence of victims for its set. The fault appears at the next replacement in that set if the bad way should be the oldest, and otherwise within at most eight back-to-back replacements of that set. Running eight replacements on a set therefore reads back its whole order. Each hit, collision and idle pattern is followed by such a run on the affected sets, and on the untouched sets too.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_HIT  = 2'd1,
    UPD_REPL = 2'd2
  } upd_src_e;
endpackage

// File: rtl/lru_rst_sync.sv
module lru_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS*AGE_W-1:0] ages_flat,
  output logic [AGE_W-1:0]      victim
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    best_age = ages_flat[AGE_W-1:0];
    victim   = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (ages_flat[i*AGE_W +: AGE_W] > best_age) begin
        best_age = ages_flat[i*AGE_W +: AGE_W];
        victim   = AGE_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_set_ages.sv
module lru_set_ages #(
  parameter int WAYS  = 8,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [AGE_W-1:0]      upd_way,
  output logic [WAYS*AGE_W-1:0] ages_flat
);
  logic [AGE_W-1:0] age_q [WAYS];
  logic [AGE_W-1:0] age_d [WAYS];
  logic [AGE_W-1:0] ref_age;

  // next-state: target becomes youngest, younger ways age by one
  always_comb begin
    ref_age = age_q[upd_way];
    for (int i = 0; i < WAYS; i++) begin
      age_d[i] = age_q[i];
      if (AGE_W'(i) == upd_way)   age_d[i] = '0;
      else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= AGE_W'(i);
    end else if (upd_en) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= age_d[i];
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_flat
    assign ages_flat[g*AGE_W +: AGE_W] = age_q[g];
  end

  // checker state
  logic [WAYS-1:0]  seen;
  logic [AGE_W-1:0] chk_way_q;
  logic             chk_upd_q;

  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[age_q[i]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_way_q <= '0;
      chk_upd_q <= 1'b0;
    end else begin
      chk_way_q <= upd_way;
      chk_upd_q <= upd_en;
    end
  end

  // R3: ages always form a permutation, so no counter overflows
  a_r3_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    (&seen));

  // R4: the way an update targets is youngest afterwards
  a_r4_target_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    chk_upd_q |-> (age_q[chk_way_q] == '0));

  // R8: a set with no update keeps its ages
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ages_flat));
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int AGE_W   = $clog2(WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic [SET_W-1:0] hit_set,
  input  logic [AGE_W-1:0] hit_way,
  input  logic             repl_valid,
  input  logic [SET_W-1:0] repl_set,
  output logic [AGE_W-1:0] victim_way
);
  import lru_pkg::*;

  logic                  rst_sn;
  logic [WAYS*AGE_W-1:0] set_ages [NUM_SETS];
  logic [WAYS*AGE_W-1:0] sel_ages;

  lru_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  assign sel_ages = set_ages[repl_set];

  lru_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
    .ages_flat (sel_ages),
    .victim    (victim_way)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    upd_src_e         src;
    logic             upd_en;
    logic [AGE_W-1:0] upd_way;

    always_comb begin
      if (repl_valid && repl_set == SET_W'(s))    src = UPD_REPL;
      else if (hit_valid && hit_set == SET_W'(s)) src = UPD_HIT;
      else                                        src = UPD_IDLE;
    end

    assign upd_en  = (src != UPD_IDLE);
    assign upd_way = (src == UPD_REPL) ? victim_way : hit_way;

    lru_set_ages #(.WAYS(WAYS), .AGE_W(AGE_W)) u_ages (
      .clk       (clk),
      .rst_n     (rst_sn),
      .upd_en    (upd_en),
      .upd_way   (upd_way),
      .ages_flat (set_ages[s])
    );
  end

  // checker state for the collision rule
  logic             clash_q;
  logic [SET_W-1:0] clash_set_q;
  logic [AGE_W-1:0] clash_way_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      clash_q     <= 1'b0;
      clash_set_q <= '0;
      clash_way_q <= '0;
    end else begin
      clash_q     <= hit_valid && repl_valid && (hit_set == repl_set) &&
                     (hit_way != victim_way);
      clash_set_q <= hit_set;
      clash_way_q <= hit_way;
    end
  end

  // R2: the returned victim holds the oldest age in its set
  a_r2_victim_oldest: assert property (@(posedge clk) disable iff (!rst_sn)
    repl_valid |-> (sel_ages[victim_way*AGE_W +: AGE_W] == AGE_W'(WAYS-1)));

  // R6: a colliding hit does not make its way youngest
  a_r6_repl_wins: assert property (@(posedge clk) disable iff (!rst_sn)
    clash_q |-> (set_ages[clash_set_q][clash_way_q*AGE_W +: AGE_W] != '0));
endmodule

// File: tb/tb_lru_age_tracker.sv
`timescale 1ns/1ps
module tb_lru_age_tracker;
  localparam int NUM_SETS = 16;
  localparam int WAYS     = 8;

  logic       clk;
  logic       rst_n;
  logic       hit_valid;
  logic [3:0] hit_set;
  logic [2:0] hit_way;
  logic       repl_valid;
  logic [3:0] repl_set;
  logic [2:0] victim_way;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    mdl [NUM_SETS][WAYS];

  lru_age_tracker #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_set    (hit_set),
    .hit_way    (hit_way),
    .repl_valid (repl_valid),
    .repl_set   (repl_set),
    .victim_way (victim_way)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int mdl_oldest(input int s);
    int best = 0;
    for (int i = 1; i < WAYS; i++) if (mdl[s][i] > mdl[s][best]) best = i;
    return best;
  endfunction

  function automatic void mdl_touch(input int s, input int w);
    int old = mdl[s][w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w)               mdl[s][i] = 0;
      else if (mdl[s][i] < old) mdl[s][i] = mdl[s][i] + 1;
    end
  endfunction

  // driver: applies one cycle of requests and records the expected victim
  task automatic step(input bit hv, input int hs, input int hw,
                      input bit rv, input int rs, input string tag);
    item_t it;
    @(negedge clk);
    hit_valid  = hv;
    hit_set    = 4'(hs);
    hit_way    = 3'(hw);
    repl_valid = rv;
    repl_set   = 4'(rs);
    if (rv) begin
      it.exp = mdl_oldest(rs);
      it.tag = tag;
      q.push_back(it);
      mdl_touch(rs, it.exp);
    end
    if (hv && !(rv && rs == hs)) mdl_touch(hs, hw);
  endtask

  task automatic drain(input int s, input string tag);
    for (int k = 0; k < WAYS; k++) step(0, 0, 0, 1, s, tag);
  endtask

  // monitor: compares the victim in the request cycle, before the edge
  always @(negedge clk) begin
    item_t it;
    #1;
    if (rst_n && repl_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: victim_way=%0d expected no request", victim_way);
      end else begin
        it = q.pop_front();
        if (int'(victim_way) != it.exp) begin
          fails++;
          $display("FAIL %s: victim_way=%0d expected %0d", it.tag, victim_way, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: cycles=100000 expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hit_valid = 1'b0; hit_set = '0; hit_way = '0;
    repl_valid = 1'b0; repl_set = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < WAYS; w++) mdl[s][w] = w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset order, R2/R10 combinational victim, R3 wrap without overflow
    step(0, 0, 0, 1, 3, "R1 reset victim set3");
    for (int k = 0; k < 9; k++) step(0, 0, 0, 1, 0, "R2 R3 R10 repl run set0");
    drain(3, "R1 R3 set3 order");

    // R4 hit to a middle-aged way
    step(1, 1, 2, 0, 0, "R4 hit");
    step(1, 1, 6, 0, 0, "R4 hit");
    drain(1, "R4 order after hits set1");

    // R5 hit to the youngest way
    step(1, 2, 0, 0, 0, "R5 hit youngest");
    drain(2, "R5 order unchanged set2");

    // R6 collision in one set
    step(1, 4, 3, 1, 4, "R6 collision victim");
    drain(4, "R6 hit ignored set4");

    // R7 hit and replacement in different sets
    step(1, 5, 1, 1, 6, "R7 split victim set6");
    drain(5, "R7 hit applied set5");
    drain(6, "R7 repl applied set6");

    // R9 request lines move while the valid bits are low
    for (int k = 0; k < 6; k++) step(0, 7, k, 0, 7, "R9 idle");
    drain(7, "R9 set7 unchanged");

    // R8 a set that nobody touched
    drain(8, "R8 untouched set8");

    // mixed traffic on a few sets to force collisions
    for (int k = 0; k < 400; k++)
      step(1'($urandom), int'($urandom % 4), int'($urandom % 8),
           1'($urandom), int'($urandom % 4), "R7 R6 mixed");
    for (int s = 0; s < 4; s++) drain(s, "R3 R4 mixed final order");

    step(0, 0, 0, 0, 0, "idle");
    step(0, 0, 0, 0, 0, "idle");
    if (q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: pending=%0d expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule